// File: doc/BRIEF.md
# Base-and-Bound Address Translator

This block turns logical addresses into physical addresses for a pipeline that keeps each program in one contiguous region of memory. It has two independent translation paths, one for instruction fetch and one for loads and stores. Each path adds the logical address to a base register to form the physical address. In the same cycle, the path compares the logical address against a limit register. An address at or beyond the limit marks the access as a violation, and the access is not granted.

Each of the four registers (fetch base, fetch limit, data base, data limit) is loaded through a small configuration port. A write takes effect only when the privileged-mode input is high. A write attempted in unprivileged mode leaves every register as it was. It also latches an error flag that stays set until reset.

The same port reads out whichever register is selected. This lets a scheduler save one program's pair and restore another's when it switches programs. Translation is purely combinational. Only the four registers and the error flag hold state.

Top module: `bb_xlate`

## Requirements
- R1: Each physical address output equals the matching base register plus the logical address, modulo 2^AW, in the same cycle that the address is presented.
- R2: When a request is high and its logical address is greater than or equal to that path's limit (unsigned compare), the fault output is 1 and the ok output is 0.
- R3: When a request is high and its address is below the limit, ok is 1 and fault is 0. When a request is low, both ok and fault are 0.
- R4: Fetch translation uses only the fetch base and limit, and data translation uses only the data base and limit. Writing one pair leaves the other path's results unchanged.
- R5: A write with `priv_mode`=1 and `cfg_we`=1 loads `cfg_wdata` into the register chosen by `cfg_sel` (0 fetch base, 1 fetch limit, 2 data base, 3 data limit). The new value is in use from the next clock edge.
- R6: A write with `priv_mode`=0 changes no register.
- R7: A write with `priv_mode`=0 sets `priv_err` at the next edge. `priv_err` then stays 1, including across later privileged writes, until reset.
- R8: `cfg_rdata` shows the register chosen by `cfg_sel` combinationally, using the same encoding as R5.
- R9: After reset, both bases are 0, both limits are all ones, and `priv_err` is 0. As a result, only the all-ones address faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 1 | 1 when the processor is in privileged mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read |
| cfg_wdata | input | AW | Write data |
| cfg_rdata | output | AW | Selected register value |
| priv_err | output | 1 | Sticky flag for an unprivileged write attempt |
| fetch_req | input | 1 | Fetch access valid |
| fetch_addr | input | AW | Fetch logical address |
| fetch_paddr | output | AW | Fetch physical address |
| fetch_ok | output | 1 | Fetch access granted |
| fetch_fault | output | 1 | Fetch limit violation |
| data_req | input | 1 | Data access valid |
| data_addr | input | AW | Data logical address |
| data_paddr | output | AW | Data physical address |
| data_ok | output | 1 | Data access granted |
| data_fault | output | 1 | Data limit violation |

## Verification
The bench loads the two paths with different bases and limits. It then drives a table of address pairs that includes zero, the last legal address, the address equal to the limit, and the all-ones address. This separates an off-by-one compare (`>` against `>=`) and detects crossed pairs between the two paths.

A base near the top of the range, combined with a large offset, checks that the sum wraps instead of saturating. Directed cases cover the following:
- the reset values and the single faulting address they leave;
- idle requests;
- an unprivileged write, checked against the readback, the translation result and the error flag;
- a later privileged write, which must not clear that flag.

// File: rtl/bb_xlate.sv
module bb_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_mode,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          priv_err,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] fetch_paddr,
  output logic          fetch_ok,
  output logic          fetch_fault,
  input  logic          data_req,
  input  logic [AW-1:0] data_addr,
  output logic [AW-1:0] data_paddr,
  output logic          data_ok,
  output logic          data_fault
);
  localparam logic [AW-1:0] LIMIT_MAX = '1;

  logic [AW-1:0] ibase, ilim, dbase, dlim;
  logic          wr_ok, wr_bad;

  assign wr_ok  = cfg_we &  priv_mode;
  assign wr_bad = cfg_we & ~priv_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibase    <= '0;
      ilim     <= LIMIT_MAX;
      dbase    <= '0;
      dlim     <= LIMIT_MAX;
      priv_err <= 1'b0;
    end else begin
      if (wr_bad) priv_err <= 1'b1;
      if (wr_ok) begin
        case (cfg_sel)
          2'd0: ibase <= cfg_wdata;
          2'd1: ilim  <= cfg_wdata;
          2'd2: dbase <= cfg_wdata;
          default: dlim <= cfg_wdata;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0: cfg_rdata = ibase;
      2'd1: cfg_rdata = ilim;
      2'd2: cfg_rdata = dbase;
      default: cfg_rdata = dlim;
    endcase
  end

  assign fetch_paddr = ibase + fetch_addr;
  assign fetch_fault = fetch_req & (fetch_addr >= ilim);
  assign fetch_ok    = fetch_req & ~fetch_fault;

  assign data_paddr  = dbase + data_addr;
  assign data_fault  = data_req & (data_addr >= dlim);
  assign data_ok     = data_req & ~data_fault;

  a_r6_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> $stable(ibase) && $stable(ilim) && $stable(dbase) && $stable(dlim));

  a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> priv_err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |=> priv_err);

  a_r5_fetch_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cfg_sel == 2'd0) |=> ibase == $past(cfg_wdata));

  a_r4_data_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cfg_sel[1] == 1'b0) |=> $stable(dbase) && $stable(dlim));
endmodule

// File: tb/bb_xlate_test.sv
module bb_xlate_test;
  localparam int AW = 16;
  localparam int NV = 5;

  logic clk = 0, rst_n = 0, priv_mode = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0, cfg_rdata;
  logic priv_err;
  logic fetch_req = 0, data_req = 0;
  logic [AW-1:0] fetch_addr = 0, data_addr = 0, fetch_paddr, data_paddr;
  logic fetch_ok, fetch_fault, data_ok, data_fault;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bb_xlate #(.AW(AW)) uut (.*);

  localparam logic [AW-1:0] FA[NV]  = '{16'h0000, 16'h03FF, 16'h0400, 16'hFFFF, 16'h0123};
  localparam logic [AW-1:0] FP[NV]  = '{16'h1000, 16'h13FF, 16'h1400, 16'h0FFF, 16'h1123};
  localparam logic          FOK[NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [AW-1:0] DA[NV]  = '{16'h0000, 16'h01FF, 16'h0200, 16'h0100, 16'h0300};
  localparam logic [AW-1:0] DP[NV]  = '{16'h8000, 16'h81FF, 16'h8200, 16'h8100, 16'h8300};
  localparam logic          DOK[NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d, input logic p);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; priv_mode = p;
    @(negedge clk);
    cfg_we = 0; priv_mode = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [AW-1:0] exp, input string req);
    cfg_sel = sel; #2;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report;
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, 16'h0000, "R9 fetch base reset");
    rd(1, 16'hFFFF, "R9 fetch limit reset");
    rd(2, 16'h0000, "R9 data base reset");
    rd(3, 16'hFFFF, "R9 data limit reset");
    chk("R9 priv_err reset", priv_err, 0);
    fetch_req = 1; fetch_addr = 16'hFFFE; #2;
    chk("R9 near-max ok", fetch_ok, 1);
    chk("R9 identity paddr", fetch_paddr, 16'hFFFE);
    fetch_addr = 16'hFFFF; #2;
    chk("R9 all-ones faults", fetch_fault, 1);
    fetch_req = 0; data_req = 0; #2;
    chk("R3 idle fetch ok", fetch_ok, 0);
    chk("R3 idle fetch fault", fetch_fault, 0);
    chk("R3 idle data ok", data_ok, 0);

    wr(0, 16'h1000, 1);
    wr(1, 16'h0400, 1);
    rd(0, 16'h1000, "R5 fetch base load");
    rd(1, 16'h0400, "R8 fetch limit readback");
    rd(2, 16'h0000, "R4 data base untouched");
    rd(3, 16'hFFFF, "R4 data limit untouched");
    wr(2, 16'h8000, 1);
    wr(3, 16'h0200, 1);
    rd(2, 16'h8000, "R8 data base readback");
    rd(3, 16'h0200, "R8 data limit readback");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fetch_req = 1; data_req = 1; fetch_addr = FA[i]; data_addr = DA[i]; #2;
      chk("R1 fetch paddr", fetch_paddr, FP[i]);
      chk("R2/R3 fetch ok", fetch_ok, FOK[i]);
      chk("R2 fetch fault", fetch_fault, !FOK[i]);
      chk("R4 data paddr", data_paddr, DP[i]);
      chk("R2/R3 data ok", data_ok, DOK[i]);
      chk("R2 data fault", data_fault, !DOK[i]);
    end

    wr(2, 16'hF000, 1);
    wr(3, 16'hFFFF, 1);
    data_addr = 16'h2000; #2;
    chk("R1 wrap paddr", data_paddr, 16'h1000);
    chk("R1 wrap ok", data_ok, 1);

    fetch_addr = 16'h0010;
    wr(0, 16'h5555, 0);
    rd(0, 16'h1000, "R6 user write ignored");
    chk("R6 fetch paddr unchanged", fetch_paddr, 16'h1010);
    chk("R7 priv_err set", priv_err, 1);
    wr(1, 16'h0800, 1);
    rd(1, 16'h0800, "R5 priv write after error");
    chk("R7 priv_err sticky", priv_err, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #2;
    chk("R7 priv_err cleared by reset", priv_err, 0);
    rd(0, 16'h0000, "R9 base after re-reset");

    done = 1;
    report;
    $finish;
  end
endmodule